// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a byte-wide processor load/store port and a memory that moves one whole block per request. Each processor address is cut into three fields. The upper bits form the tag. The middle bits select the one line where that address may live. The low bits pick a byte inside the line. Every line keeps a valid flag, a dirty flag, a tag and a four-byte block. A load that hits returns the addressed byte in the same cycle the request is seen. A store that hits replaces that byte and marks the line dirty.

On a miss a small controller takes over. If the resident line holds modified data, that block goes back to memory first, at an address rebuilt from the stored tag and the line number. The wanted block is then fetched. Stores allocate on a miss: the fetched block is merged with the new byte and the line is left dirty. Loads leave a freshly filled line clean. The processor keeps its request asserted until it sees the one-cycle completion pulse. The hit flag is reported in that same cycle.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_done` and `mem_req` are low, and the first access to any address completes as a miss.
- R2: A hit requires the line's valid flag and a stored tag equal to the address tag. A line still holding its reset tag of 0 while invalid misses for an address whose tag is 0.
- R3: Address bits [7:5] are the tag, bits [4:2] are the line number and bits [1:0] are the byte offset. Blocks with different line numbers coexist, and blocks with the same line number but different tags displace each other.
- R4: A load hit raises `cpu_done` and `cpu_hit` in the cycle the request is presented, with no memory request. `cpu_rdata` is byte k of the block, which is block bits [8k+7:8k], where k is the offset.
- R5: A miss on a clean or invalid line issues one read request (`mem_we`=0) with `mem_addr` equal to address bits [7:2]. The access completes with `cpu_done`=1 and `cpu_hit`=0 in the cycle `mem_ready` is seen, and a load returns the offset byte of `mem_rdata`.
- R6: A miss on a dirty line first issues a write request (`mem_we`=1). Its `mem_addr` is {stored tag, line number} and its `mem_wdata` is the current line block. Only after that write is accepted does the read request for the new block follow.
- R7: A store hit replaces only the addressed byte, keeps the other three, and marks the line dirty, so the line is written back when it is evicted.
- R8: A store miss fetches the block, merges the new byte into it and leaves the line valid and dirty.
- R9: A line filled by a load stays clean, so evicting it issues no write request.
- R10: `mem_req`, `mem_addr` and `mem_we` stay unchanged from the first cycle of a request until the cycle `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed access was a hit |
| mem_req | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = write-back, 0 = block read |
| mem_addr | output | 6 | Block address |
| mem_wdata | output | 32 | Block written back |
| mem_ready | input | 1 | Memory accepts or answers the request this cycle |
| mem_rdata | input | 32 | Block returned for a read |

## Verification
Two functions can meet in one cycle. The first is completing a miss: the line write, the merge of a store byte into the returned block, and the `cpu_done` pulse all happen on the same `mem_ready` cycle as the fill data. The second is the switch from write-back to fill, which takes place on the edge where the write is accepted. The bench provokes both with store misses onto dirty lines and with memory latencies of zero to three cycles. A scoreboard judges them. It predicts each write-back block and each fill address from its own model of line state and memory contents. It then checks that a load of the stored byte hits and returns the merged value, and that a later eviction writes that value back.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } dmc_state_e;

    typedef struct packed {
        dmc_state_e st;
    } dmc_ctrl_s;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 3,
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             wr_dirty,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_blk
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q, valid_d;
    logic [LINES-1:0] dirty_q, dirty_d;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [TAG_W-1:0] tag_d [LINES];
    logic [BLK_W-1:0] blk_q [LINES];
    logic [BLK_W-1:0] blk_d [LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        tag_d   = tag_q;
        blk_d   = blk_q;
        if (wr_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = wr_dirty;
            tag_d[idx]   = wr_tag;
            blk_d[idx]   = wr_blk;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                blk_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            tag_q   <= tag_d;
            blk_q   <= blk_d;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_blk   = blk_q[idx];

    // R7: a modified line is always a resident line
    p_dirty_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dirty |-> rd_valid);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_valid,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [BYTE_W-1:0]           cpu_wdata,
    output logic [BYTE_W-1:0]           cpu_rdata,
    output logic                        cpu_done,
    output logic                        cpu_hit,
    output logic [IDX_W-1:0]            ln_idx,
    output logic                        ln_wr_en,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] ln_wr_tag,
    output logic [(BYTE_W<<OFF_W)-1:0]  ln_wr_blk,
    output logic                        ln_wr_dirty,
    input  logic                        ln_valid,
    input  logic                        ln_dirty,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] ln_tag,
    input  logic [(BYTE_W<<OFF_W)-1:0]  ln_blk,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-OFF_W-1:0]     mem_addr,
    output logic [(BYTE_W<<OFF_W)-1:0]  mem_wdata,
    input  logic                        mem_ready,
    input  logic [(BYTE_W<<OFF_W)-1:0]  mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = BYTE_W << OFF_W;

    dmc_ctrl_s r_q, r_d;

    logic [TAG_W-1:0] a_tag;
    logic [OFF_W-1:0] a_off;
    logic             lookup_hit;
    logic [BLK_W-1:0] src_blk;
    logic [BLK_W-1:0] merged_blk;
    logic [BYTE_W-1:0] picked;

    always_comb begin
        a_tag      = cpu_addr[ADDR_W-1 -: TAG_W];
        ln_idx     = cpu_addr[OFF_W +: IDX_W];
        a_off      = cpu_addr[OFF_W-1:0];
        lookup_hit = ln_valid && (ln_tag == a_tag);

        src_blk    = (r_q.st == ST_FILL) ? mem_rdata : ln_blk;
        picked     = src_blk[int'(a_off)*BYTE_W +: BYTE_W];
        merged_blk = src_blk;
        merged_blk[int'(a_off)*BYTE_W +: BYTE_W] = cpu_wdata;

        r_d         = r_q;
        cpu_done    = 1'b0;
        cpu_hit     = 1'b0;
        cpu_rdata   = picked;
        ln_wr_en    = 1'b0;
        ln_wr_tag   = a_tag;
        ln_wr_blk   = cpu_we ? merged_blk : src_blk;
        ln_wr_dirty = cpu_we;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = {a_tag, ln_idx};
        mem_wdata   = ln_blk;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (lookup_hit) begin
                        cpu_done    = 1'b1;
                        cpu_hit     = 1'b1;
                        ln_wr_en    = cpu_we;
                        ln_wr_dirty = 1'b1;
                    end else if (ln_valid && ln_dirty) begin
                        r_d.st = ST_WBACK;
                    end else begin
                        r_d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {ln_tag, ln_idx};
                if (mem_ready) r_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    cpu_done = 1'b1;
                    ln_wr_en = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= ST_IDLE;
        else        r_q    <= r_d;
    end

    // R10: request fields hold until memory answers
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R6: an accepted write-back is followed by the block read
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready |=> mem_req && !mem_we);
    // R5: the read answer completes the access as a miss
    p_fill_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |-> cpu_done && !cpu_hit);
    // R4: a hit completes with no memory traffic and only for a live request
    p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_hit |-> !mem_req && cpu_valid);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_valid,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [7:0]                 cpu_wdata,
    output logic [7:0]                 cpu_rdata,
    output logic                       cpu_done,
    output logic                       cpu_hit,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-OFF_W-1:0]    mem_addr,
    output logic [(8<<OFF_W)-1:0]      mem_wdata,
    input  logic                       mem_ready,
    input  logic [(8<<OFF_W)-1:0]      mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = BYTE_W << OFF_W;

    logic [IDX_W-1:0] ln_idx;
    logic             ln_wr_en, ln_wr_dirty, ln_valid, ln_dirty;
    logic [TAG_W-1:0] ln_wr_tag, ln_tag;
    logic [BLK_W-1:0] ln_wr_blk, ln_blk;

    dmc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .ln_idx(ln_idx), .ln_wr_en(ln_wr_en), .ln_wr_tag(ln_wr_tag),
        .ln_wr_blk(ln_wr_blk), .ln_wr_dirty(ln_wr_dirty),
        .ln_valid(ln_valid), .ln_dirty(ln_dirty), .ln_tag(ln_tag), .ln_blk(ln_blk),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) i_lines (
        .clk(clk), .rst_n(rst_n), .idx(ln_idx),
        .wr_en(ln_wr_en), .wr_tag(ln_wr_tag), .wr_blk(ln_wr_blk),
        .wr_dirty(ln_wr_dirty),
        .rd_valid(ln_valid), .rd_dirty(ln_dirty), .rd_tag(ln_tag), .rd_blk(ln_blk)
    );
endmodule

// File: tb/test_dmc_cache.sv
module test_dmc_cache;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_we;
    logic [7:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_done, cpu_hit;
    logic        mem_req, mem_we, mem_ready;
    logic [5:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #(CLK_P/2) clk = ~clk;

    dmc_cache i_dmc_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int lat = 1;
    bit finished = 0;

    typedef struct { bit we; bit hit; logic [7:0] rd; string tag; } done_t;
    typedef struct { logic [5:0] a; logic [31:0] d; } wb_t;
    done_t      q_done[$];
    wb_t        q_wb[$];
    logic [5:0] q_fill[$];

    logic [7:0]  ref_mem [256];
    logic [31:0] bk_mem  [64];
    bit          rv   [8];
    bit          rdty [8];
    logic [2:0]  rt   [8];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_blk(input logic [5:0] b);
        return {ref_mem[{b,2'd3}], ref_mem[{b,2'd2}], ref_mem[{b,2'd1}], ref_mem[{b,2'd0}]};
    endfunction

    // memory responder; R10 request fields must not move while waiting
    initial begin
        int cnt;
        bit tracking;
        logic [5:0] first_a;
        bit first_we;
        cnt = 0; tracking = 0; first_a = '0; first_we = 0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
                tracking = 0;
            end else if (mem_req) begin
                if (!tracking) begin
                    tracking = 1;
                    first_a  = mem_addr;
                    first_we = mem_we;
                end else begin
                    check(mem_addr == first_a && mem_we == first_we, "R10",
                          {25'd0, mem_we, mem_addr}, {25'd0, first_we, first_a});
                end
                if (cnt >= lat) begin
                    mem_ready = 1'b1;
                    if (mem_we) bk_mem[mem_addr] = mem_wdata;
                    else        mem_rdata = bk_mem[mem_addr];
                end else begin
                    cnt++;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        done_t e;
        wb_t w;
        logic [5:0] fa;
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (cpu_done) begin
                if (q_done.size() == 0) check(0, "R4", 1, 0);
                else begin
                    e = q_done.pop_front();
                    check(cpu_hit == e.hit, e.tag, {31'd0, cpu_hit}, {31'd0, e.hit});
                    if (!e.we) check(cpu_rdata == e.rd, e.tag, {24'd0, cpu_rdata}, {24'd0, e.rd});
                end
            end
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    if (q_wb.size() == 0) check(0, "R9", {26'd0, mem_addr}, 32'hffff_ffff);
                    else begin
                        w = q_wb.pop_front();
                        check(mem_addr == w.a, "R6", {26'd0, mem_addr}, {26'd0, w.a});
                        check(mem_wdata == w.d, "R6", mem_wdata, w.d);
                    end
                end else begin
                    if (q_fill.size() == 0) check(0, "R5", {26'd0, mem_addr}, 32'hffff_ffff);
                    else begin
                        fa = q_fill.pop_front();
                        check(mem_addr == fa, "R5", {26'd0, mem_addr}, {26'd0, fa});
                    end
                end
            end
        end
    end

    // driver: called at a falling edge, returns at a falling edge
    task automatic access(input bit we, input logic [7:0] a, input logic [7:0] d, input string tag);
        logic [2:0] idx, tg;
        bit hit, seen;
        done_t e;
        wb_t w;
        idx = a[4:2];
        tg  = a[7:5];
        hit = rv[idx] && (rt[idx] == tg);
        if (!hit) begin
            if (rdty[idx]) begin
                w.a = {rt[idx], idx};
                w.d = ref_blk({rt[idx], idx});
                q_wb.push_back(w);
            end
            q_fill.push_back({tg, idx});
            rv[idx] = 1; rt[idx] = tg; rdty[idx] = 0;
        end
        if (we) begin
            ref_mem[a] = d;
            rdty[idx] = 1;
        end
        e.we = we; e.hit = hit; e.rd = ref_mem[a]; e.tag = tag;
        q_done.push_back(e);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            #(CLK_P/4);
            seen = cpu_done;
            @(negedge clk);
            if (seen) break;
        end
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1-R10 run: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'((i * 37 + 11) & 255);
        for (int b = 0; b < 64; b++) bk_mem[b] = ref_blk(6'(b));
        for (int i = 0; i < 8; i++) begin rv[i] = 0; rdty[i] = 0; rt[i] = '0; end
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/4);
        check(cpu_done == 1'b0, "R1", {31'd0, cpu_done}, 0);
        check(mem_req == 1'b0, "R1", {31'd0, mem_req}, 0);
        @(negedge clk);

        // R2: tag 0 matches reset tag of invalid line 3 -> miss
        lat = 1;
        access(0, 8'h0C, 8'h00, "R2");
        access(0, 8'h0D, 8'h00, "R4");
        access(0, 8'h0F, 8'h00, "R4");
        // R3: other lines coexist
        access(0, 8'h10, 8'h00, "R1");
        access(0, 8'hE2, 8'h00, "R3");
        access(0, 8'h0E, 8'h00, "R3");
        access(0, 8'h13, 8'h00, "R3");
        // R7: store hit then read neighbours and the byte
        access(1, 8'h0E, 8'hA5, "R7");
        access(0, 8'h0E, 8'h00, "R7");
        access(0, 8'h0C, 8'h00, "R7");
        // R6: conflict evicts dirty line 3
        lat = 0;
        access(0, 8'h2C, 8'h00, "R6");
        // R9: clean line 3 evicted without write-back
        lat = 3;
        access(0, 8'h0E, 8'h00, "R9");
        // R8: store miss allocates and dirties line 4
        lat = 2;
        access(1, 8'h71, 8'h3C, "R8");
        access(0, 8'h71, 8'h00, "R8");
        access(0, 8'h70, 8'h00, "R8");
        access(0, 8'h91, 8'h00, "R8");
        // store miss onto a dirty line
        access(1, 8'hB0, 8'h5A, "R6");
        access(1, 8'h50, 8'h77, "R6");
        access(0, 8'h50, 8'h00, "R8");

        // mixed traffic
        lf = 8'h5B;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            lat = i % 4;
            access(lf[0], {lf[7:5] & 3'b101, lf[4:2] & 3'b011, lf[1:0]}, lf ^ 8'h3A, "R3");
        end
        repeat (2) @(negedge clk);
        check(q_done.size() == 0, "R4", q_done.size(), 0);
        check(q_wb.size() == 0, "R6", q_wb.size(), 0);
        check(q_fill.size() == 0, "R5", q_fill.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule